// File: doc/BRIEF.md
# Multi-Channel PWM Bank with Synchronized Value Updates

A bank of PWM generators, three by default and up to four. Each generator has a down-counter, a period (load) value and two compare values, and drives one output. Software reaches the bank through a single-cycle write port. A separate register clears the counters of any chosen set of generators together, which brings their waveforms into phase.

The load and compare values are written through shadow copies. Each generator's control register chooses when those copies reach the counter logic:
- at once;
- at the generator's next counter-zero;
- at the first counter-zero that follows a commit request.

The third mode lets software stage new values in several generators and then swap all of them at one boundary. Before that boundary each generator runs on its whole old set of values, and after it on the whole new set. The output-enable register has its own per-generator choice between an immediate update and an update deferred to counter-zero.

A per-generator status output shows the commit request bit. Software can poll it to see that a commit has been done.

Top module: `pwm_sync_bank`

## Requirements
- R1: While reset is asserted and right after it is released, every bit of pwmOut and updPending is 0. All load values, compare values, modes and enables start at 0.
- R2: Each counter counts down by one per cycle. In the cycle after it reads 0 it reloads the active load value L, so the period is L+1 cycles. The output is set when the counter is at zero and cleared when the counter equals compare A (0 < A <= L). This gives L-A+1 high cycles and A low cycles per period.
- R3: When 0 < B < A, a counter value equal to compare B sets the output high again. The low time then becomes A-B cycles.
- R4: The global registers sit at wrAddr 16 to 19, selected by bits [1:0]. Writing address 16 with data bit g set forces counter g to 0 in the next cycle. All generators selected in one write are cleared in the same cycle, and their outputs run in lockstep from then on.
- R5: The generator registers sit at wrAddr = {1'b0, gen[1:0], field[1:0]}, with field 0 = mode, 1 = load, 2 = compare A and 3 = compare B. When mode bit 0 is 0 (immediate), a load or compare write is active from the next clock cycle.
- R6: Mode 2'b01 (local) holds written values as pending. They become active at that generator's next counter-zero, so the period in progress finishes on the old values.
- R7: Mode 2'b11 (global) moves pending values to the active set only at the first counter-zero after the generator's request bit was set. The request bit is set by writing data bit g to address 17. Until then the generator runs on its full old set of values.
- R8: One request write with several bits set commits the selected generators at the same clock edge when their counters are aligned. Their outputs stay identical across the change.
- R9: updPending[g] shows request bit g. It stays set until generator g's next counter-zero and clears at that edge.
- R10: Enable bit g (address 18) gates pwmOut[g]. Enable-mode bit g (address 19, reset 0) selects the update: 0 means the new enable is active from the next cycle, and 1 means it is deferred to generator g's counter-zero.
- R11: A deferred write that arrives in the counter-zero cycle of its generator is the value committed at that boundary, and the reload uses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | 5 | Register address |
| wrData | input | CNT_W | Write data |
| pwmOut | output | NUM_GEN | PWM outputs, one per generator |
| updPending | output | NUM_GEN | Commit request bits still waiting for counter-zero |

## Verification
The assertions assume that the sync register and the request register select only existing generators. They also assume that software does not set a generator's request bit in the same cycle in which that generator's counter reads zero, because that would re-arm a request that is being retired. The stimulus places every request, and every staged write that is meant to wait, in the middle of a period, away from the zero cycle. The one write aimed at the zero cycle is timed from a sync write, whose zero cycle is known exactly.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int ADDR_W = 5;

  // generator register fields, wrAddr[1:0]
  localparam logic [1:0] FLD_MODE = 2'd0;
  localparam logic [1:0] FLD_LOAD = 2'd1;
  localparam logic [1:0] FLD_CMPA = 2'd2;
  localparam logic [1:0] FLD_CMPB = 2'd3;

  // global registers, wrAddr[1:0] with wrAddr[4:2] = 3'b100
  localparam logic [1:0] GREG_SYNC = 2'd0;
  localparam logic [1:0] GREG_REQ  = 2'd1;
  localparam logic [1:0] GREG_EN   = 2'd2;
  localparam logic [1:0] GREG_ENMD = 2'd3;

  // slot order of the value registers inside one generator
  localparam int SLOT_LOAD = 0;
  localparam int SLOT_CMPA = 1;
  localparam int SLOT_CMPB = 2;
  localparam int NUM_SLOT  = 3;

  typedef struct packed {
    logic wrLoad;
    logic wrCmpA;
    logic wrCmpB;
    logic immed;    // writes go straight to the active set
    logic commit;   // copy pending set to active set this cycle
    logic syncClr;  // force the counter to zero
  } genStrobe_t;
endpackage

// File: rtl/pwm_sync_ctrl.sv
module pwm_sync_ctrl
  import pwm_sync_pkg::*;
#(
  parameter int NUM_GEN = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_GEN-1:0] wrBits,
  input  logic [NUM_GEN-1:0] zeroFlag,
  output genStrobe_t         strobe [NUM_GEN],
  output logic [NUM_GEN-1:0] enActive,
  output logic [NUM_GEN-1:0] updPending
);
  logic       genBank, glbBank;
  logic [1:0] fld, genSel;
  logic       syncWr, reqWr, enWr, enModeWr;

  assign genBank  = wrEn && !wrAddr[ADDR_W-1];
  assign glbBank  = wrEn && wrAddr[ADDR_W-1] && (wrAddr[3:2] == 2'b00);
  assign fld      = wrAddr[1:0];
  assign genSel   = wrAddr[3:2];
  assign syncWr   = glbBank && (fld == GREG_SYNC);
  assign reqWr    = glbBank && (fld == GREG_REQ);
  assign enWr     = glbBank && (fld == GREG_EN);
  assign enModeWr = glbBank && (fld == GREG_ENMD);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_ctl
    logic       hit;
    logic [1:0] mode;
    logic       reqBit, enPend, enDefer, enAct;
    genStrobe_t stb;

    assign hit = genBank && (genSel == 2'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      mode <= 2'b00;
      else if (hit && fld == FLD_MODE) mode <= wrBits[1:0];
    end

    always_comb begin
      stb.wrLoad  = hit && (fld == FLD_LOAD);
      stb.wrCmpA  = hit && (fld == FLD_CMPA);
      stb.wrCmpB  = hit && (fld == FLD_CMPB);
      stb.immed   = !mode[0];
      stb.commit  = zeroFlag[g] && mode[0] && (!mode[1] || reqBit);
      stb.syncClr = syncWr && wrBits[g];
    end
    assign strobe[g] = stb;

    // request bit: set by software, retired at the next counter-zero
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    reqBit <= 1'b0;
      else if (reqWr && wrBits[g])  reqBit <= 1'b1;
      else if (zeroFlag[g])         reqBit <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enDefer <= 1'b0;
        enPend  <= 1'b0;
        enAct   <= 1'b0;
      end else begin
        if (enModeWr) enDefer <= wrBits[g];
        if (enWr)     enPend  <= wrBits[g];
        if (!enDefer) begin
          if (enWr) enAct <= wrBits[g];
        end else if (zeroFlag[g]) begin
          enAct <= enWr ? wrBits[g] : enPend;
        end
      end
    end

    assign updPending[g] = reqBit;
    assign enActive[g]   = enAct;
  end
endmodule

// File: rtl/pwm_sync_gen.sv
module pwm_sync_gen
  import pwm_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  genStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic             zeroFlag,
  output logic             rawOut
);
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    active [NUM_SLOT];
  logic [CNT_W-1:0]    nxt    [NUM_SLOT];
  logic [NUM_SLOT-1:0] wrHit;

  assign wrHit    = {strobe.wrCmpB, strobe.wrCmpA, strobe.wrLoad};
  assign zeroFlag = (cnt == '0);

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    logic [CNT_W-1:0] shReg, acReg, nxVal;

    always_comb begin
      nxVal = acReg;
      if (wrHit[i] && strobe.immed) nxVal = wrData;
      else if (strobe.commit)       nxVal = wrHit[i] ? wrData : shReg;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg <= '0;
        acReg <= '0;
      end else begin
        if (wrHit[i]) shReg <= wrData;
        acReg <= nxVal;
      end
    end

    assign active[i] = acReg;
    assign nxt[i]    = nxVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.syncClr) cnt <= '0;
    else if (zeroFlag)       cnt <= nxt[SLOT_LOAD];
    else                     cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           rawOut <= 1'b0;
    else if (zeroFlag)                   rawOut <= 1'b1;
    else if (cnt == active[SLOT_CMPA])   rawOut <= 1'b0;
    else if (cnt == active[SLOT_CMPB])   rawOut <= 1'b1;
  end
endmodule

// File: rtl/pwm_sync_bank.sv
module pwm_sync_bank
  import pwm_sync_pkg::*;
#(
  parameter int NUM_GEN = 3,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  output logic [NUM_GEN-1:0] pwmOut,
  output logic [NUM_GEN-1:0] updPending
);
  genStrobe_t         strobe [NUM_GEN];
  logic [NUM_GEN-1:0] zeroFlag, rawOut, enActive;

  pwm_sync_ctrl #(.NUM_GEN(NUM_GEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrBits     (wrData[NUM_GEN-1:0]),
    .zeroFlag   (zeroFlag),
    .strobe     (strobe),
    .enActive   (enActive),
    .updPending (updPending)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    pwm_sync_gen #(.CNT_W(CNT_W)) u_gen (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe[g]),
      .wrData   (wrData),
      .zeroFlag (zeroFlag[g]),
      .rawOut   (rawOut[g])
    );
  end

  assign pwmOut = rawOut & enActive;
endmodule

// File: rtl/pwm_sync_bank_chk.sv
module pwm_sync_bank_chk
  import pwm_sync_pkg::*;
#(
  parameter int NUM_GEN = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [NUM_GEN-1:0] wrBits,
  input logic [NUM_GEN-1:0] zeroFlag,
  input logic [NUM_GEN-1:0] rawOut,
  input logic [NUM_GEN-1:0] updPending
);
  logic syncWr, reqWr;
  assign syncWr = wrEn && (wrAddr == {3'b100, GREG_SYNC});
  assign reqWr  = wrEn && (wrAddr == {3'b100, GREG_REQ});

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    // R4: a selected counter reads zero in the next cycle
    a_r4_sync_clears: assert property (@(posedge clk) disable iff (!rstN)
      (syncWr && wrBits[g]) |=> zeroFlag[g]);

    // R2: the output is high in the cycle after counter-zero
    a_r2_high_after_zero: assert property (@(posedge clk) disable iff (!rstN)
      zeroFlag[g] |=> rawOut[g]);

    // R7: a request waits until the counter reaches zero
    a_r7_request_waits: assert property (@(posedge clk) disable iff (!rstN)
      (updPending[g] && !zeroFlag[g]) |=> updPending[g]);

    // R9: a request is retired at counter-zero
    a_r9_request_clears: assert property (@(posedge clk) disable iff (!rstN)
      (updPending[g] && zeroFlag[g] && !(reqWr && wrBits[g])) |=> !updPending[g]);
  end
endmodule

bind pwm_sync_bank pwm_sync_bank_chk #(.NUM_GEN(NUM_GEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrBits     (wrData[NUM_GEN-1:0]),
  .zeroFlag   (zeroFlag),
  .rawOut     (rawOut),
  .updPending (updPending)
);

// File: tb/pwm_sync_bank_test.sv
`timescale 1ns/1ps
module pwm_sync_bank_test;
  localparam int NG = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [4:0]    wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic [NG-1:0] pwmOut, updPending;

  pwm_sync_bank #(.NUM_GEN(NG), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .updPending(updPending)
  );

  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard of expected output runs on generator 0
  typedef struct { bit lvl; int len; string req; } run_t;
  run_t expQ[$];
  bit   armReq = 0, armed = 0, monLvl = 0, prevS = 0;
  int   runLen = 0;

  task automatic pushRun(input bit l, input int n, input string r);
    run_t e;
    e.lvl = l; e.len = n; e.req = r;
    expQ.push_back(e);
  endtask

  always @(negedge clk) begin : monitor
    run_t e;
    bit   cur;
    cur = pwmOut[0];
    if (armReq && cur && !prevS) begin
      armReq = 0; armed = 1; monLvl = 1; runLen = 1;
    end else if (armed) begin
      if (cur == monLvl) runLen++;
      else begin
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
          check(e.lvl == monLvl && e.len == runLen, e.req,
                monLvl * 1000 + runLen, e.lvl * 1000 + e.len);
        end
        monLvl = cur;
        runLen = 1;
      end
    end
    prevS = cur;
  end

  // lockstep monitor for generators 0 and 1
  bit pairWatch = 0;
  int pairMis = 0;
  always @(negedge clk) if (pairWatch && (pwmOut[0] != pwmOut[1])) pairMis++;

  initial begin : watchdog
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [4:0] gAddr(input int g, input logic [1:0] f);
    return {1'b0, 2'(g), f};
  endfunction
  function automatic logic [4:0] cAddr(input logic [1:0] r);
    return {3'b100, r};
  endfunction

  // called at a negedge; the write lands on the next posedge
  task automatic doWrite(input logic [4:0] a, input int d);
    wrAddr = a; wrData = CW'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitQueue(input int n, input string r);
    for (int i = 0; i < 3000 && expQ.size() > n; i++) @(negedge clk);
    check(expQ.size() <= n, r, expQ.size(), n);
  endtask

  task automatic drain(input string r);
    waitQueue(0, r);
    armed = 0; armReq = 0;
  endtask

  task automatic waitRise0();
    bit last;
    last = pwmOut[0];
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (pwmOut[0] && !last) break;
      last = pwmOut[0];
    end
  endtask

  initial begin : driver
    idle(3);
    check(pwmOut == '0, "R1 outputs in reset", pwmOut, 0);
    check(updPending == '0, "R1 pending in reset", updPending, 0);
    rstN = 1'b1;
    idle(2);
    check(pwmOut == '0, "R1 outputs after reset", pwmOut, 0);
    check(updPending == '0, "R1 pending after reset", updPending, 0);

    // R2: immediate mode, L=9 A=4 -> 6 high, 4 low
    doWrite(gAddr(0, 2'd1), 9);
    doWrite(gAddr(0, 2'd2), 4);
    doWrite(cAddr(2'd2), 7);
    idle(25);
    for (int k = 0; k < 2; k++) begin pushRun(1, 6, "R2"); pushRun(0, 4, "R2"); end
    armReq = 1;
    drain("R2 drain");

    // R5: immediate compare write is active from the next cycle
    waitRise0();                // counter holds 9 in this cycle
    doWrite(gAddr(0, 2'd2), 7); // counter 8 now
    check(pwmOut[0] == 1'b1, "R5 before match", pwmOut[0], 1);
    idle(1);
    check(pwmOut[0] == 1'b1, "R5 at match cycle", pwmOut[0], 1);
    idle(1);
    check(pwmOut[0] == 1'b0, "R5 new compare used", pwmOut[0], 0);
    doWrite(gAddr(0, 2'd2), 4);

    // R3: compare B = 2 sets the output again
    doWrite(gAddr(0, 2'd3), 2);
    idle(30);
    for (int k = 0; k < 2; k++) begin pushRun(1, 8, "R3"); pushRun(0, 2, "R3"); end
    armReq = 1;
    drain("R3 drain");
    doWrite(gAddr(0, 2'd3), 0);
    idle(30);

    // R6: local mode, period change 9 -> 5 at the boundary
    doWrite(gAddr(0, 2'd0), 1);
    idle(10);
    pushRun(1, 6, "R6 old"); pushRun(0, 4, "R6 old");
    armReq = 1;
    waitQueue(1, "R6 wait");
    pushRun(1, 2, "R6 new"); pushRun(0, 4, "R6 new");
    pushRun(1, 2, "R6 new"); pushRun(0, 4, "R6 new");
    doWrite(gAddr(0, 2'd1), 5);
    drain("R6 drain");

    // R4: generator 1 one cycle out of phase, then sync 0 and 1
    waitRise0();
    doWrite(gAddr(1, 2'd1), 5);
    doWrite(gAddr(1, 2'd2), 4);
    idle(12);
    pairMis = 0; pairWatch = 1;
    idle(12);
    pairWatch = 0;
    check(pairMis > 0, "R4 out of phase before sync", pairMis, 1);
    doWrite(cAddr(2'd0), 3);
    idle(2);
    pairMis = 0; pairWatch = 1;
    idle(24);
    pairWatch = 0;
    check(pairMis == 0, "R4 lockstep after sync", pairMis, 0);

    // R7 R8 R9: global mode on generators 0 and 1
    doWrite(gAddr(0, 2'd0), 3);
    doWrite(gAddr(1, 2'd0), 3);
    idle(14);
    pairMis = 0; pairWatch = 1;
    for (int k = 0; k < 3; k++) begin pushRun(1, 2, "R7 old"); pushRun(0, 4, "R7 old"); end
    armReq = 1;
    waitQueue(1, "R7 wait");
    for (int k = 0; k < 2; k++) begin pushRun(1, 2, "R7 held"); pushRun(0, 4, "R7 held"); end
    doWrite(gAddr(0, 2'd1), 11);
    doWrite(gAddr(0, 2'd2), 3);
    doWrite(gAddr(1, 2'd1), 11);
    doWrite(gAddr(1, 2'd2), 3);
    check(updPending == '0, "R9 no request yet", updPending, 0);
    waitQueue(1, "R7 wait held");
    for (int k = 0; k < 2; k++) begin pushRun(1, 9, "R7 new"); pushRun(0, 3, "R7 new"); end
    doWrite(cAddr(2'd1), 3);
    check(updPending == 3'b011, "R9 request visible", updPending, 3);
    drain("R7 drain");
    check(updPending == '0, "R9 request retired", updPending, 0);
    pairWatch = 0;
    check(pairMis == 0, "R8 joint commit", pairMis, 0);

    // R10: enable register, immediate then deferred
    doWrite(gAddr(2, 2'd1), 7);
    idle(20);
    doWrite(cAddr(2'd2), 3);
    check(pwmOut[2] == 1'b0, "R10 immediate disable", pwmOut[2], 0);
    doWrite(cAddr(2'd2), 7);
    check(pwmOut[2] == 1'b1, "R10 immediate enable", pwmOut[2], 1);
    doWrite(cAddr(2'd3), 4);
    doWrite(cAddr(2'd0), 4);    // counter 2 at zero
    idle(1);                    // reload to 7
    doWrite(cAddr(2'd2), 3);    // counter 6
    check(pwmOut[2] == 1'b1, "R10 deferred held", pwmOut[2], 1);
    idle(6);                    // counter 0
    check(pwmOut[2] == 1'b1, "R10 held until zero", pwmOut[2], 1);
    idle(1);
    check(pwmOut[2] == 1'b0, "R10 applied at zero", pwmOut[2], 0);

    // R11: local write in the zero cycle is committed and reloaded
    doWrite(gAddr(2, 2'd2), 1);
    doWrite(gAddr(2, 2'd0), 1);
    doWrite(cAddr(2'd3), 0);
    doWrite(cAddr(2'd2), 7);
    idle(20);
    doWrite(cAddr(2'd0), 4);    // counter 2 reads zero in the next cycle
    doWrite(gAddr(2, 2'd1), 3); // lands on the zero cycle
    idle(2);
    check(pwmOut[2] == 1'b1, "R11 high before compare", pwmOut[2], 1);
    idle(1);
    check(pwmOut[2] == 1'b0, "R11 short period low", pwmOut[2], 0);
    idle(1);
    check(pwmOut[2] == 1'b1, "R11 reload with new value", pwmOut[2], 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule